// File: doc/BRIEF.md
# Cascaded Board Interrupt Aggregator

This block is a secondary interrupt controller for a board with a handful of level-type interrupt requests. It captures each request into a per-source status bit. It combines the captured bits with a per-source mask and raises one cascade request towards a primary interrupt controller. Only one cascade input of the primary controller is needed for all of the board sources.

Software controls the block through a small register interface. It turns capture on or off per source through separate set and clear addresses, and it masks or unmasks the cascade contribution per source in the same way. In the interrupt handler, software reads the status register and writes the value it read straight back, which acknowledges every bit it saw. It then services those sources from the lowest index upward. Bits that arrive between the read and the write-back are kept.

Top module: `board_irq_cascade`

## Requirements
- R1: After reset the status, enable and mask bitmaps are all zero (every source is disabled and masked), every address reads zero and `cascade_irq` is low.
- R2: A write to address 1 sets every enable bit that is 1 in the write data, and a write to address 2 clears every enable bit that is 1 in the data. Bits written as 0 are unchanged. Address 1 reads back the enable bitmap and address 2 always reads 0.
- R3: A write to address 3 sets every mask bit that is 1 in the data, which unmasks those sources, and a write to address 4 clears every such bit, which masks them. Address 3 reads back the mask bitmap and address 4 always reads 0.
- R4: Status bit k (address 0, bit k for source k) becomes 1 at a clock edge where `src[k]` is high and enable bit k is 1. A source whose enable bit is 0 never sets its status bit.
- R5: A write to address 0 clears exactly the status bits that are 1 in the write data and leaves every other status bit unchanged.
- R6: When a source sets its status bit on the same edge as a write to address 0 that clears that bit, the bit ends up set.
- R7: `cascade_irq` is high exactly one cycle after some bit is 1 in both status and mask, and low one cycle after no such bit exists.
- R8: A status bit stays set after its source input drops, until software clears it.
- R9: A masked source still sets its status bit, but it does not raise `cascade_irq`.
- R10: Addresses 5 to 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | 16 | Level interrupt requests, one per source |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| cascade_irq | output | 1 | Registered cascade request to the primary controller |

## Verification
A single source is walked across all sixteen positions. Each one is enabled, unmasked, pulsed, acknowledged and then disabled, which separates bit placement, latching after the source drops, and the one-cycle lag of the cascade output. Fixed patterns then cover specific cases. Requests arriving with the enable bit off show that the enable gates capture. A pattern held while masked shows that the mask gates only the output. A partial write-back shows that acknowledge is exact per bit. A write-back that coincides with a live request shows that the set path has priority. A long pseudo-random run mixes writes to every address, including the unused ones, with random source patterns. On every cycle it compares the read data and the cascade output against an arithmetic model.

// File: rtl/board_irq_cascade.sv
module board_irq_cascade #(
  parameter int NSRC = 16,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            cascade_irq
);
  localparam logic [AW-1:0] A_STAT   = AW'(0);
  localparam logic [AW-1:0] A_EN_SET = AW'(1);
  localparam logic [AW-1:0] A_EN_CLR = AW'(2);
  localparam logic [AW-1:0] A_MK_SET = AW'(3);
  localparam logic [AW-1:0] A_MK_CLR = AW'(4);

  logic [NSRC-1:0] status_q, enable_q, allow_q;
  logic [NSRC-1:0] ack_bits, hit_bits;

  assign ack_bits = (bus_wr && bus_addr == A_STAT) ? bus_wdata : '0;
  assign hit_bits = src & enable_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q    <= '0;
      enable_q    <= '0;
      allow_q     <= '0;
      cascade_irq <= 1'b0;
    end else begin
      status_q    <= (status_q & ~ack_bits) | hit_bits;
      cascade_irq <= |(status_q & allow_q);
      if (bus_wr && bus_addr == A_EN_SET) enable_q <= enable_q | bus_wdata;
      if (bus_wr && bus_addr == A_EN_CLR) enable_q <= enable_q & ~bus_wdata;
      if (bus_wr && bus_addr == A_MK_SET) allow_q  <= allow_q | bus_wdata;
      if (bus_wr && bus_addr == A_MK_CLR) allow_q  <= allow_q & ~bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:   bus_rdata = status_q;
      A_EN_SET: bus_rdata = enable_q;
      A_MK_SET: bus_rdata = allow_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

module board_irq_cascade_chk #(
  parameter int NSRC = 16,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] bus_rdata,
  input logic            cascade_irq,
  input logic [NSRC-1:0] st,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] al
);
  AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & $past(src & en)) == $past(src & en))); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & ~$past(st) & ~$past(en)) == '0)); // R4
  AST_ACK_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(0)) |=> ((st & $past(bus_wdata & ~(src & en))) == '0)); // R5
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(0)) |=> ((st & $past(st)) == $past(st))); // R8
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st & al)) |=> cascade_irq); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(st & al)) |=> !cascade_irq); // R7
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(1)) |=> ((en & $past(bus_wdata)) == $past(bus_wdata))); // R2
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(4)) |=> ((al & $past(bus_wdata)) == '0)); // R3
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(2) || bus_addr == AW'(4)) |-> (bus_rdata == '0)); // R2
  AST_UNUSED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr > AW'(4)) |=> ($stable(en) && $stable(al))); // R10
endmodule

bind board_irq_cascade board_irq_cascade_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src(src), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cascade_irq(cascade_irq),
  .st(status_q), .en(enable_q), .al(allow_q)
);

// File: tb/sim_board_irq_cascade.sv
module sim_board_irq_cascade;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] src = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cascade_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_st = '0, m_en = '0, m_al = '0;
  logic        m_irq = 0;

  board_irq_cascade u0 (.clk(clk), .rst_n(rst_n), .src(src), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cascade_irq(cascade_irq));

  always #10 clk = ~clk;

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_st;
      3'd1: return m_en;
      3'd3: return m_al;
      default: return 16'h0;
    endcase
  endfunction

  task automatic expect16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive, check current outputs, advance one clock.
  task automatic step(input string tag, input logic [2:0] a, input logic w,
                      input logic [15:0] d, input logic [15:0] s);
    logic [15:0] clr;
    bus_addr = a; bus_wr = w; bus_wdata = d; src = s;
    #1;
    expect16({tag, " rdata"}, bus_rdata, m_read(a));
    expect16({tag, " irq"}, {15'h0, cascade_irq}, {15'h0, m_irq});
    @(posedge clk);
    clr = (w && a == 3'd0) ? d : 16'h0;
    m_irq = |(m_st & m_al);
    m_st = (m_st & ~clr) | (s & m_en);
    if (w && a == 3'd1) m_en = m_en | d;
    if (w && a == 3'd2) m_en = m_en & ~d;
    if (w && a == 3'd3) m_al = m_al | d;
    if (w && a == 3'd4) m_al = m_al & ~d;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state at every address
    for (int a = 0; a < 8; a++) step("R1 reset", 3'(a), 1'b0, 16'h0, 16'h0);

    // R4 R7 R8 R5 R2 R3: walk one source across all positions
    for (int k = 0; k < 16; k++) begin
      step("R2 en set", 3'd1, 1'b1, 16'h1 << k, 16'h0);
      step("R3 mask set", 3'd3, 1'b1, 16'h1 << k, 16'h0);
      step("R4 pulse", 3'd0, 1'b0, 16'h0, 16'h1 << k);
      step("R8 latched", 3'd0, 1'b0, 16'h0, 16'h0);
      step("R7 irq high", 3'd0, 1'b0, 16'h0, 16'h0);
      step("R5 ack", 3'd0, 1'b1, m_st, 16'h0);
      step("R7 irq low", 3'd0, 1'b0, 16'h0, 16'h0);
      step("R2 en clr", 3'd2, 1'b1, 16'h1 << k, 16'h0);
      step("R3 mask clr", 3'd4, 1'b1, 16'h1 << k, 16'h0);
      step("R2 readback", 3'd1, 1'b0, 16'h0, 16'h0);
      step("R3 readback", 3'd3, 1'b0, 16'h0, 16'h0);
    end

    // R4: disabled sources never capture
    step("R4 disabled", 3'd0, 1'b0, 16'h0, 16'hFFFF);
    step("R4 disabled", 3'd0, 1'b0, 16'h0, 16'h0);
    expect16("R4 disabled status", bus_rdata, 16'h0);

    // R9: masked source captures but no irq
    step("R9 en all", 3'd1, 1'b1, 16'hFFFF, 16'h0);
    step("R9 pulse", 3'd0, 1'b0, 16'h0, 16'hA5A5);
    step("R9 status", 3'd0, 1'b0, 16'h0, 16'h0);
    step("R9 irq", 3'd0, 1'b0, 16'h0, 16'h0);
    expect16("R9 status value", bus_rdata, 16'hA5A5);
    expect16("R9 irq low", {15'h0, cascade_irq}, 16'h0);

    // R5: partial acknowledge
    step("R5 partial", 3'd0, 1'b1, 16'h00FF, 16'h0);
    step("R5 partial", 3'd0, 1'b0, 16'h0, 16'h0);
    expect16("R5 partial value", bus_rdata, 16'hA500);

    // R6: capture beats simultaneous clear
    step("R6 race", 3'd0, 1'b1, 16'hFFFF, 16'h0100);
    step("R6 race", 3'd0, 1'b0, 16'h0, 16'h0);
    expect16("R6 race value", bus_rdata, 16'h0100);

    // R2 R3: clear addresses read zero
    step("R3 mask some", 3'd3, 1'b1, 16'h0F0F, 16'h0);
    step("R2 clr reads 0", 3'd2, 1'b0, 16'h0, 16'h0);
    expect16("R2 clr addr", bus_rdata, 16'h0);
    step("R3 clr reads 0", 3'd4, 1'b0, 16'h0, 16'h0);
    expect16("R3 clr addr", bus_rdata, 16'h0);

    // R10: unused addresses
    for (int a = 5; a < 8; a++) begin
      step("R10 write", 3'(a), 1'b1, 16'hFFFF, 16'h0);
      step("R10 read", 3'(a), 1'b0, 16'h0, 16'h0);
    end
    step("R10 en kept", 3'd1, 1'b0, 16'h0, 16'h0);
    expect16("R10 enable", bus_rdata, 16'hFFFF);
    step("R10 mask kept", 3'd3, 1'b0, 16'h0, 16'h0);
    expect16("R10 mask", bus_rdata, 16'h0F0F);

    // R4 R5 R6 R7 R2 R3 R10: pseudo-random mix
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] r1, r2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r1 = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r2 = lfsr;
      step("R4 R5 R6 R7 random", r1[2:0], r1[3],
           (r1[2:0] == 3'd0 && r1[4]) ? m_st : r2,
           r1[15:8] == 8'h00 ? r2 : (r2 & {r1[15:8], r1[7:0]} & 16'h1248));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule